// File: doc/BRIEF.md
# Sub-Audible Tone Synthesizer with Pulse-Width Output

This block produces a low-frequency signalling tone by direct digital synthesis and emits it as one pulse-width-modulated bit. A wide phase register advances once per output frame by a step chosen from a parameter table. The upper phase bits address a computed sine table, and that sample sets how many clocks of the next frame the output stays high. An external two-stage RC filter turns the bit stream into an analog sine.

The default step table suits a 1.8432 MHz clock. With 256-clock frames that clock gives 7200 sample updates per second. Each default entry equals round(f × 2^32 / 7200) for tones from 67.0 Hz to 88.5 Hz, which keeps every tone well inside 0.4 % of its nominal value.

The user picks a tone with a 3-bit select. A narrow-mode input limits the choice to the lower half of the table. A transmit-key input mutes the tone and freezes the phase.

Top module: `tone_synth_pwm`

## Requirements
- R1: `rst` is synchronous and active high. While it is asserted the phase is set to 0, the frame counter to 0, the duty to 128 (mid-scale) and the tone is enabled. The first frame after release is therefore high for exactly 128 clocks.
- R2: A frame lasts 256 clocks. Within a frame the output is high for the first D clocks and low for the rest, where D is the current duty. D changes only at a frame boundary.
- R3: The phase register is 32 bits wide. At each boundary that is not muted, the selected step is added modulo 2^32, and the fractional (lower) bits carry into the upper bits.
- R4: At each boundary that is not muted, the duty of the next frame becomes S(p). Here p is the top 8 phase bits as they stood before that boundary's addition.
- R5: S(k) stays within ±1 of 128 + round(127·sin(2πk/256)). S(0) = S(128) = 128, S(64) = 255 and S(192) = 1, and S is never 0.
- R6: The step equals table entry `tone_sel`, with entry i at bits [32i+31:32i] of `INC_TABLE`. `tone_sel` is sampled at the boundary.
- R7: When `narrow_mode` is 1, bit 2 of `tone_sel` is treated as 0, so only entries 0 to 3 can be chosen.
- R8: From the clock after `ptt` is sampled high, the output is low. Boundaries that see `ptt` high leave both the phase and the duty unchanged.
- R9: After `ptt` falls, the output stays low until the next boundary. From that boundary on, the duty is S of the held phase and the phase advances again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_sel | input | 3 | Step table index |
| narrow_mode | input | 1 | Forces the top index bit to 0 |
| ptt | input | 1 | High mutes the tone and holds the phase |
| pwm_out | output | 1 | Pulse-width-modulated tone |

## Verification
The bench swaps in a step table of round numbers, so that the expected duty of every frame can be derived from a phase model. A design that added a fraction wrongly, or dropped a carry, would drift off the half-step sequence. A design that sampled the phase after the addition would shift every sample by one frame. A design that left the top select bit live in narrow mode would show the wrong quarter-wave sequence.

Muting is checked at its edges. The frame in which `ptt` rises must show exactly one high clock. The frame in which `ptt` falls must stay fully low, and the frame after it must resume from the held phase rather than a skipped one. The bench also probes the sine peaks and troughs for exact values, and checks that the high time always forms one block at the start of the frame.

// File: rtl/tone_pkg.sv
package tone_pkg;

    // Sine sample for table address k with w-bit width, using a rational
    // half-wave approximation; amplitude mid-1 around mid = 2**(w-1).
    function automatic int sine_point(int k, int w);
        longint n;
        longint h;
        longint amp;
        longint kk;
        longint prod;
        longint num;
        longint den;
        longint mag;
        n    = longint'(1) << w;
        h    = n / 2;
        amp  = h - 1;
        kk   = longint'(k) % h;
        prod = kk * (h - kk);
        num  = amp * 16 * prod;
        den  = 5 * h * h - 4 * prod;
        mag  = (num + den / 2) / den;
        if (longint'(k) < h) begin
            return int'(h + mag);
        end
        return int'(h - mag);
    endfunction

endpackage

// File: rtl/tone_frame_timer.sv
module tone_frame_timer #(
    parameter int PWM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [PWM_W-1:0] cnt_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [PWM_W-1:0] cnt;
    } timer_t;

    timer_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = &st_q.cnt;

    p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (cnt_o == '0));

endmodule

// File: rtl/tone_phase_acc.sv
module tone_phase_acc #(
    parameter int ACC_W = 32,
    parameter int SEL_W = 3,
    parameter int PWM_W = 8,
    parameter logic [(2**SEL_W)*ACC_W-1:0] INC_TABLE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic [SEL_W-1:0] tone_sel,
    input  logic             narrow_mode,
    output logic [PWM_W-1:0] phase_o
);
    localparam int TONES = 2 ** SEL_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } phase_t;

    phase_t st_d, st_q;
    logic [SEL_W-1:0] idx_eff;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] table_w [TONES];

    generate
        for (genvar g = 0; g < TONES; g++) begin : g_inc
            assign table_w[g] = INC_TABLE[g*ACC_W +: ACC_W];
        end
    endgenerate

    always_comb begin
        idx_eff = tone_sel;
        if (narrow_mode) begin
            idx_eff[SEL_W-1] = 1'b0;
        end
        step = table_w[idx_eff];
        st_d = st_q;
        if (step_en) begin
            st_d.acc = st_q.acc + step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.acc[ACC_W-1 -: PWM_W];

    p_phase_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(st_q.acc));

endmodule

// File: rtl/tone_sine_rom.sv
module tone_sine_rom #(
    parameter int PWM_W = 8
) (
    input  logic [PWM_W-1:0] addr,
    output logic [PWM_W-1:0] sample
);
    localparam int DEPTH = 2 ** PWM_W;

    logic [PWM_W-1:0] rom [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_rom
            assign rom[g] = PWM_W'(tone_pkg::sine_point(g, PWM_W));
        end
    endgenerate

    assign sample = rom[addr];

    always_comb begin
        a_sample_floor_r5: assert (sample != '0);
    end

endmodule

// File: rtl/tone_synth_pwm.sv
module tone_synth_pwm #(
    parameter int PWM_W = 8,
    parameter int ACC_W = 32,
    parameter int SEL_W = 3,
    parameter logic [(2**SEL_W)*ACC_W-1:0] INC_TABLE = {
        32'd52792306, 32'd50943084, 32'd49213167, 32'd47542902,
        32'd45932289, 32'd44381329, 32'd42890021, 32'd39967057
    }
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] tone_sel,
    input  logic             narrow_mode,
    input  logic             ptt,
    output logic             pwm_out
);
    localparam logic [PWM_W-1:0] MID = PWM_W'(1) << (PWM_W - 1);

    typedef struct packed {
        logic [PWM_W-1:0] cmp;
        logic             run;
    } out_t;

    out_t st_d, st_q;
    logic [PWM_W-1:0] cnt;
    logic             wrap;
    logic             step_en;
    logic [PWM_W-1:0] phase;
    logic [PWM_W-1:0] sample;

    tone_frame_timer #(.PWM_W(PWM_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    tone_phase_acc #(
        .ACC_W     (ACC_W),
        .SEL_W     (SEL_W),
        .PWM_W     (PWM_W),
        .INC_TABLE (INC_TABLE)
    ) u_phase (
        .clk         (clk),
        .rst         (rst),
        .step_en     (step_en),
        .tone_sel    (tone_sel),
        .narrow_mode (narrow_mode),
        .phase_o     (phase)
    );

    tone_sine_rom #(.PWM_W(PWM_W)) u_rom (
        .addr   (phase),
        .sample (sample)
    );

    assign step_en = wrap && !ptt;

    always_comb begin
        st_d = st_q;
        if (ptt) begin
            st_d.run = 1'b0;
        end else if (wrap) begin
            st_d.run = 1'b1;
            st_d.cmp = sample;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cmp <= MID;
            st_q.run <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_out = st_q.run && (cnt < st_q.cmp);

    p_ptt_mutes_r8: assert property (@(posedge clk) disable iff (rst)
        ptt |=> !pwm_out);

    p_resume_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (!st_q.run && !wrap) |=> !pwm_out);

    p_cmp_boundary_r2: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(st_q.cmp));

    p_duty_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        st_q.cmp != '0);

endmodule

// File: tb/tb_tone_synth_pwm.sv
module tb_tone_synth_pwm;
    localparam logic [255:0] TB_INC = {
        32'h8000_0000, 32'h4000_0000, 32'h2000_0000, 32'h1000_0000,
        32'h0400_0000, 32'h0080_0000, 32'h0200_0000, 32'h0100_0000
    };
    localparam int LIMIT = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] tone_sel = 3'd0;
    logic       narrow_mode = 1'b0;
    logic       ptt = 1'b0;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_acc = '0;
    int m_cmp = 128;
    int m_tol = 0;
    bit m_run = 1'b1;

    always #10 clk = ~clk;

    tone_synth_pwm #(.INC_TABLE(TB_INC)) dut (
        .clk         (clk),
        .rst         (rst),
        .tone_sel    (tone_sel),
        .narrow_mode (narrow_mode),
        .ptt         (ptt),
        .pwm_out     (pwm_out)
    );

    function automatic int exp_sample(int k);
        real v;
        v = 127.0 * $sin(2.0 * 3.14159265358979 * k / 256.0);
        return 128 + int'($floor(v + 0.5));
    endfunction

    function automatic logic [31:0] inc_of(logic [2:0] sel, logic nar);
        logic [2:0] idx;
        idx = sel;
        if (nar) idx[2] = 1'b0;
        return TB_INC[idx*32 +: 32];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_acc = '0;
        m_cmp = 128;
        m_tol = 0;
        m_run = 1'b1;
    endtask

    // One aligned frame; ptt_edge marks the frame in which ptt was just raised.
    task automatic run_frame(input string req, input bit ptt_edge);
        int hi;
        int expv;
        int diff;
        int k;
        bit seen_low;
        bit prefix_ok;
        hi = 0;
        seen_low = 1'b0;
        prefix_ok = 1'b1;
        for (int i = 0; i < 256; i++) begin
            if (pwm_out) begin
                hi++;
                if (seen_low) prefix_ok = 1'b0;
            end else begin
                seen_low = 1'b1;
            end
            @(negedge clk);
        end
        if (ptt_edge) begin
            expv = m_run ? 1 : 0;
            diff = hi - expv;
            check(diff == 0, {req, " ptt rise"}, hi, expv);
            m_run = 1'b0;
        end else begin
            expv = m_run ? m_cmp : 0;
            diff = (hi > expv) ? hi - expv : expv - hi;
            check(diff <= (m_run ? m_tol : 0), req, hi, expv);
        end
        check(prefix_ok, "R2 high block at frame start", int'(prefix_ok), 1);
        if (!ptt) begin
            k = int'(m_acc[31:24]);
            m_cmp = exp_sample(k);
            m_tol = (k % 64 == 0) ? 0 : 1;
            m_acc = m_acc + inc_of(tone_sel, narrow_mode);
            m_run = 1'b1;
        end
    endtask

    task automatic t_reset_r1();
        tone_sel = 3'd0; narrow_mode = 1'b0; ptt = 1'b0;
        do_reset();
        run_frame("R1 mid-scale first frame", 1'b0);
        run_frame("R1 phase zero sample", 1'b0);
    endtask

    task automatic t_unit_step_r4();
        tone_sel = 3'd0;
        do_reset();
        for (int f = 0; f < 6; f++) run_frame("R4 unit step sequence", 1'b0);
    endtask

    task automatic t_quarter_r5();
        tone_sel = 3'd6;
        do_reset();
        for (int f = 0; f < 9; f++) run_frame("R5 quarter-wave peaks", 1'b0);
    endtask

    task automatic t_carry_r3();
        tone_sel = 3'd2;
        do_reset();
        for (int f = 0; f < 6; f++) run_frame("R3 fractional carry", 1'b0);
        tone_sel = 3'd7;
        for (int f = 0; f < 4; f++) run_frame("R3 modulo wrap", 1'b0);
    endtask

    task automatic t_select_r6();
        do_reset();
        tone_sel = 3'd1;
        run_frame("R6 select entry 1", 1'b0);
        tone_sel = 3'd4;
        run_frame("R6 select entry 4", 1'b0);
        tone_sel = 3'd5;
        for (int f = 0; f < 3; f++) run_frame("R6 select entry 5", 1'b0);
        tone_sel = 3'd3;
        for (int f = 0; f < 3; f++) run_frame("R6 select entry 3", 1'b0);
    endtask

    task automatic t_narrow_r7();
        do_reset();
        narrow_mode = 1'b1;
        tone_sel = 3'd6;
        for (int f = 0; f < 5; f++) run_frame("R7 narrow 6 acts as 2", 1'b0);
        tone_sel = 3'd7;
        for (int f = 0; f < 4; f++) run_frame("R7 narrow 7 acts as 3", 1'b0);
        narrow_mode = 1'b0;
        tone_sel = 3'd6;
        for (int f = 0; f < 3; f++) run_frame("R7 full range restored", 1'b0);
    endtask

    task automatic t_ptt_r8_r9();
        do_reset();
        tone_sel = 3'd6;
        run_frame("R8 lead-in", 1'b0);
        run_frame("R8 lead-in", 1'b0);
        ptt = 1'b1;
        run_frame("R8 mute onset", 1'b1);
        run_frame("R8 muted frame", 1'b0);
        run_frame("R8 muted frame", 1'b0);
        ptt = 1'b0;
        run_frame("R9 low until boundary", 1'b0);
        for (int f = 0; f < 4; f++) run_frame("R9 resume from held phase", 1'b0);
    endtask

    initial begin
        t_reset_r1();
        t_unit_step_r4();
        t_quarter_r5();
        t_carry_r3();
        t_select_r6();
        t_narrow_r7();
        t_ptt_r8_r9();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", LIMIT);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule